// File: doc/BRIEF.md
# SMBus Voltage-ID Register Slave

This block is an SMBus slave for a core-voltage regulator controller. It holds two 5-bit voltage-ID words and one enable bit for the power converters. A host sets and reads these values with the SMBus Write Word and Read Word protocols. A select input picks which of the two ID words drives the `vid` output. The regulator's feedback network uses that output. The `smbOn` output must be high before the converters may start.

The bus pins are oversampled on a fast system clock. SCL and SDA are synchronised, and START and STOP are found from SDA moving while SCL is high. The slave acknowledges only its own address. Only the top three bits of the command byte are decoded. Of the eight combinations, the four with bit 7 clear are valid. The two data bytes of a word map to register 0 (low byte) and register 1 (high byte). The ID value sits in bits 7..3 of each byte. SDA is open drain: `sdaOe` high pulls the line to `sdaOut`, which is always 0.

Top module: `smb_vid_slave`

## Requirements
- R1: After reset both ID registers read 11111b, `smbOn` is 0 and `sdaOe` is 0.
- R2: Only the 7-bit address 1110001b (write byte E2h, read byte E3h) is acknowledged (SDA low in the ninth clock). For any other address no byte of the transfer is acknowledged and no register changes.
- R3: `sdaOe` changes only after a falling SCL edge. Host data is sampled on rising SCL.
- R4: A command with bit 7 set is acknowledged but has no effect: a Write Word changes nothing, and a Read Word leaves SDA released, so both bytes read FFh.
- R5: A Write Word whose command bits 7..5 are 001 (bits 4..0 don't care) loads bits 7..3 of Data Low into register 0 and bits 7..3 of Data High into register 1 (byte bit 7 is ID bit 4). The update happens only after the Data High byte is acknowledged. A STOP before that leaves both registers unchanged.
- R6: `vid` shows register 0 when `sel` is 0 and register 1 when `sel` is 1.
- R7: A Write Word with command bits 7..5 = 010 sets `smbOn` to bit 0 of Data Low.
- R8: A Read Word (command write, repeated START, read address) with command bits 7..5 = 000 or 001 returns register 0 and then register 1, each in bits 7..3 with bits 2..0 zero.
- R9: A Read Word with command bits 7..5 = 010 or 011 returns `smbOn` in bit 0 of the low byte and 00h as the high byte.
- R10: If the host NACKs the low byte of a read, the slave releases SDA until the next START.
- R11: A Write Word with command bits 7..5 = 000 or 011 changes neither the ID registers nor `smbOn`.
- R12: A repeated START restarts the address phase and keeps the command already received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaOe | output | 1 | High pulls SDA to `sdaOut` |
| sdaOut | output | 1 | Level driven when enabled (always 0) |
| sel | input | 1 | Picks ID register 0 (0) or 1 (1) for `vid` |
| vid | output | 5 | Selected voltage-ID word |
| smbOn | output | 1 | Converter enable written over the bus |

## Verification
Word writes use byte values whose bits 2..0 are non-zero, and bit patterns that differ between the two bytes. This separates the byte-to-register mapping and the field position from a swap or a shift. Reads are tried with each command class: ID words, the enable bit, and invalid commands. They are also tried with an early host NACK. The ack slots of a foreign address, and writes cut short by STOP, show whether state is ever touched outside a complete addressed transfer. Writes with reserved-but-valid and invalid commands are checked against both `vid` views and `smbOn`.

// File: rtl/smb_vid_pkg.sv
package smb_vid_pkg;
  localparam int BYTE_BITS = 8;
  localparam logic [2:0] CMD_VID = 3'b001;
  localparam logic [2:0] CMD_ON  = 3'b010;

  typedef struct packed {
    logic rxShift;
    logic cmdLoad;
    logic loLoad;
    logic commit;
    logic txLoad;
    logic txSel;
    logic txShift;
  } strobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK, S_WAIT
  } busState_t;

  typedef enum logic [1:0] {
    P_ADDR, P_CMD, P_LO, P_HI
  } phase_t;
endpackage

// File: rtl/smb_vid_sync.sv
module smb_vid_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaBit,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev, sdaPrev;

  genvar i;
  generate
    for (i = 0; i < SYNC_STAGES; i++) begin : gStage
      if (i == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sclPipe[0] <= 1'b1;
            sdaPipe[0] <= 1'b1;
          end else begin
            sclPipe[0] <= sclIn;
            sdaPipe[0] <= sdaIn;
          end
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sclPipe[i] <= 1'b1;
            sdaPipe[i] <= 1'b1;
          end else begin
            sclPipe[i] <= sclPipe[i-1];
            sdaPipe[i] <= sdaPipe[i-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclPipe[SYNC_STAGES-1];
      sdaPrev <= sdaPipe[SYNC_STAGES-1];
    end
  end

  logic sclNow;
  assign sclNow  = sclPipe[SYNC_STAGES-1];
  assign sdaBit  = sdaPipe[SYNC_STAGES-1];
  assign sclRise = sclNow & ~sclPrev;
  assign sclFall = ~sclNow & sclPrev;
  assign startEv = sclNow & sclPrev & sdaPrev & ~sdaBit;
  assign stopEv  = sclNow & sclPrev & ~sdaPrev & sdaBit;
endmodule

// File: rtl/smb_vid_ctrl.sv
module smb_vid_ctrl
  import smb_vid_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclRise,
  input  logic    sclFall,
  input  logic    startEv,
  input  logic    stopEv,
  input  logic    sdaBit,
  input  logic    addrMatch,
  input  logic    rwBit,
  input  logic    txBit,
  input  logic    txEn,
  output strobe_t strobe,
  output logic    sdaOe
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

  busState_t state, stateN;
  phase_t    phase, phaseN;
  logic [CNT_W-1:0] bitCnt, bitCntN;
  logic readQ, readN;
  logic txIdx, txIdxN;
  logic hostAck, hostAckN;

  always_comb begin
    strobe   = '0;
    stateN   = state;
    phaseN   = phase;
    bitCntN  = bitCnt;
    readN    = readQ;
    txIdxN   = txIdx;
    hostAckN = hostAck;
    if (startEv) begin
      stateN  = S_RX;
      phaseN  = P_ADDR;
      bitCntN = '0;
    end else if (stopEv) begin
      stateN = S_IDLE;
    end else begin
      unique case (state)
        S_RX: begin
          if (sclRise && bitCnt != FULL) begin
            strobe.rxShift = 1'b1;
            bitCntN = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL) begin
            bitCntN = '0;
            stateN  = S_RXACK;
            unique case (phase)
              P_ADDR: begin
                if (addrMatch) readN = rwBit;
                else stateN = S_WAIT;
              end
              P_CMD:   strobe.cmdLoad = 1'b1;
              P_LO:    strobe.loLoad = 1'b1;
              default: ;
            endcase
          end
        end
        S_RXACK: begin
          if (sclFall) begin
            unique case (phase)
              P_ADDR: begin
                if (readQ) begin
                  strobe.txLoad = 1'b1;
                  strobe.txSel  = 1'b0;
                  txIdxN = 1'b0;
                  stateN = S_TX;
                end else begin
                  stateN = S_RX;
                  phaseN = P_CMD;
                end
              end
              P_CMD: begin stateN = S_RX; phaseN = P_LO; end
              P_LO:  begin stateN = S_RX; phaseN = P_HI; end
              default: begin
                strobe.commit = 1'b1;
                stateN = S_WAIT;
              end
            endcase
          end
        end
        S_TX: begin
          if (sclRise) begin
            bitCntN = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == FULL) begin
              bitCntN = '0;
              stateN  = S_TXACK;
            end else begin
              strobe.txShift = 1'b1;
            end
          end
        end
        S_TXACK: begin
          if (sclRise) begin
            hostAckN = ~sdaBit;
          end else if (sclFall) begin
            if (hostAck && !txIdx) begin
              strobe.txLoad = 1'b1;
              strobe.txSel  = 1'b1;
              txIdxN = 1'b1;
              stateN = S_TX;
            end else begin
              stateN = S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phase   <= P_ADDR;
      bitCnt  <= '0;
      readQ   <= 1'b0;
      txIdx   <= 1'b0;
      hostAck <= 1'b0;
    end else begin
      state   <= stateN;
      phase   <= phaseN;
      bitCnt  <= bitCntN;
      readQ   <= readN;
      txIdx   <= txIdxN;
      hostAck <= hostAckN;
    end
  end

  assign sdaOe = (state == S_RXACK) | ((state == S_TX) & txEn & ~txBit);
endmodule

// File: rtl/smb_vid_data.sv
module smb_vid_data
  import smb_vid_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'b1110001,
  parameter int         VID_W      = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             sdaBit,
  output logic             addrMatch,
  output logic             rwBit,
  output logic             txBit,
  output logic             txEn,
  output logic [VID_W-1:0] regVid0,
  output logic [VID_W-1:0] regVid1,
  output logic             smbOn
);
  localparam int PAD_W = BYTE_BITS - VID_W;
  localparam logic [VID_W-1:0] VID_RESET = '1;

  logic [BYTE_BITS-1:0] rxShiftQ, cmdQ, loQ, txShiftQ;
  logic [BYTE_BITS-1:0] readLo, readHi;

  assign addrMatch = (rxShiftQ[BYTE_BITS-1:1] == SLAVE_ADDR);
  assign rwBit     = rxShiftQ[0];
  assign txBit     = txShiftQ[BYTE_BITS-1];
  assign txEn      = ~cmdQ[7];

  always_comb begin
    if (cmdQ[6]) begin
      readLo = {{(BYTE_BITS-1){1'b0}}, smbOn};
      readHi = '0;
    end else begin
      readLo = {regVid0, {PAD_W{1'b0}}};
      readHi = {regVid1, {PAD_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShiftQ <= '0;
      cmdQ     <= '0;
      loQ      <= '0;
      txShiftQ <= '1;
    end else begin
      if (strobe.rxShift) rxShiftQ <= {rxShiftQ[BYTE_BITS-2:0], sdaBit};
      if (strobe.cmdLoad) cmdQ <= rxShiftQ;
      if (strobe.loLoad)  loQ  <= rxShiftQ;
      if (strobe.txLoad)  txShiftQ <= strobe.txSel ? readHi : readLo;
      else if (strobe.txShift) txShiftQ <= {txShiftQ[BYTE_BITS-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regVid0 <= VID_RESET;
      regVid1 <= VID_RESET;
      smbOn   <= 1'b0;
    end else if (strobe.commit) begin
      if (cmdQ[7:5] == CMD_VID) begin
        regVid0 <= loQ[BYTE_BITS-1 -: VID_W];
        regVid1 <= rxShiftQ[BYTE_BITS-1 -: VID_W];
      end else if (cmdQ[7:5] == CMD_ON) begin
        smbOn <= loQ[0];
      end
    end
  end
endmodule

// File: rtl/smb_vid_slave.sv
module smb_vid_slave
  import smb_vid_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'b1110001,
  parameter int         VID_W       = 5,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  output logic             sdaOut,
  input  logic             sel,
  output logic [VID_W-1:0] vid,
  output logic             smbOn
);
  logic sdaBit, sclRise, sclFall, startEv, stopEv;
  logic addrMatch, rwBit, txBit, txEn;
  logic [VID_W-1:0] regVid0, regVid1;
  strobe_t strobe;

  smb_vid_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaBit(sdaBit), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  smb_vid_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaBit(sdaBit),
    .addrMatch(addrMatch), .rwBit(rwBit), .txBit(txBit), .txEn(txEn),
    .strobe(strobe), .sdaOe(sdaOe)
  );

  smb_vid_data #(.SLAVE_ADDR(SLAVE_ADDR), .VID_W(VID_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaBit),
    .addrMatch(addrMatch), .rwBit(rwBit), .txBit(txBit), .txEn(txEn),
    .regVid0(regVid0), .regVid1(regVid1), .smbOn(smbOn)
  );

  assign sdaOut = 1'b0;
  assign vid    = sel ? regVid1 : regVid0;
endmodule

// File: rtl/smb_vid_checks.sv
module smb_vid_checks #(
  parameter int VID_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclFall,
  input logic             sdaOe,
  input logic             commit,
  input logic             sel,
  input logic [VID_W-1:0] vid,
  input logic [VID_W-1:0] regVid0,
  input logic [VID_W-1:0] regVid1,
  input logic             smbOn
);
  assert_reset_vals_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (regVid0 == '1 && regVid1 == '1 && !smbOn && !sdaOe));

  assert_sda_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> $past(sclFall));

  assert_vid_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(regVid0) || !$stable(regVid1)) |-> $past(commit));

  assert_vid_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(sel) && $stable(regVid0) && $stable(regVid1)) |-> $stable(vid));

  assert_on_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(smbOn) |-> $past(commit));
endmodule

bind smb_vid_slave smb_vid_checks #(.VID_W(VID_W)) u_checks (
  .clk(clk), .rstN(rstN), .sclFall(sclFall), .sdaOe(sdaOe),
  .commit(strobe.commit), .sel(sel), .vid(vid),
  .regVid0(regVid0), .regVid1(regVid1), .smbOn(smbOn)
);

// File: tb/sim_smb_vid_slave.sv
`timescale 1ns/1ps
module sim_smb_vid_slave;
  localparam int Q = 8;

  typedef struct {
    string      tag;
    logic [7:0] val;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic hostLow = 1'b0;
  logic sel = 1'b0;
  logic sdaOe, sdaOut, smbOn;
  logic [4:0] vid;
  logic sdaLine;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  expItem_t expQ[$];
  logic [7:0] obsVal;
  event obsEv;

  always #4 clk = ~clk;

  assign sdaLine = hostLow ? 1'b0 : (sdaOe ? sdaOut : 1'b1);

  smb_vid_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .sdaOut(sdaOut), .sel(sel), .vid(vid), .smbOn(smbOn)
  );

  // Monitor: pops an expected item for every observation.
  initial begin
    forever begin
      @(obsEv);
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected item: actual %02h expected none", obsVal);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (obsVal !== it.val) begin
          errors++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, obsVal, it.val);
        end
      end
    end
  end

  task automatic expect_item(input string tag, input logic [7:0] v);
    expItem_t it;
    it.tag = tag;
    it.val = v;
    expQ.push_back(it);
  endtask

  task automatic observe(input logic [7:0] v);
    obsVal = v;
    ->obsEv;
    @(negedge clk);
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    hostLow = 1'b0; waitQ(1);
    sclDrv = 1'b1;  waitQ(1);
    hostLow = 1'b1; waitQ(1);
    sclDrv = 1'b0;  waitQ(1);
  endtask

  task automatic busStop();
    hostLow = 1'b1; waitQ(1);
    sclDrv = 1'b1;  waitQ(1);
    hostLow = 1'b0; waitQ(2);
  endtask

  task automatic writeBit(input logic b);
    hostLow = ~b; waitQ(1);
    sclDrv = 1'b1; waitQ(2);
    sclDrv = 1'b0; waitQ(1);
  endtask

  task automatic readBit(output logic b);
    hostLow = 1'b0; waitQ(1);
    sclDrv = 1'b1; waitQ(1);
    b = sdaLine;   waitQ(1);
    sclDrv = 1'b0; waitQ(1);
  endtask

  // Sends one byte; the ack slot level is observed (0 = ACK).
  task automatic sendByte(input logic [7:0] v, input string tag, input logic expAck);
    logic a;
    expect_item(tag, {7'b0, expAck});
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(a);
    observe({7'b0, a});
  endtask

  task automatic recvByte(input logic [7:0] expV, input string tag, input logic hostAcks);
    logic [7:0] v;
    logic b;
    expect_item(tag, expV);
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    writeBit(~hostAcks);
    observe(v);
  endtask

  task automatic writeWord(input logic [7:0] addr, input logic [7:0] cmd,
                           input logic [7:0] lo, input logic [7:0] hi,
                           input string tag, input logic expAck);
    busStart();
    sendByte(addr, tag, expAck);
    sendByte(cmd, tag, expAck);
    sendByte(lo, tag, expAck);
    sendByte(hi, tag, expAck);
    busStop();
  endtask

  task automatic readWord(input logic [7:0] cmd, input logic [7:0] expLo,
                          input logic [7:0] expHi, input string tag);
    busStart();
    sendByte(8'hE2, tag, 1'b0);
    sendByte(cmd, tag, 1'b0);
    busStart(); // repeated START
    sendByte(8'hE3, tag, 1'b0);
    recvByte(expLo, tag, 1'b1);
    recvByte(expHi, tag, 1'b0);
    busStop();
  endtask

  task automatic checkPorts(input logic [4:0] v0, input logic [4:0] v1,
                            input logic on, input string tag);
    sel = 1'b0; repeat (2) @(negedge clk);
    expect_item({tag, " vid sel0"}, {3'b0, v0}); observe({3'b0, vid});
    sel = 1'b1; repeat (2) @(negedge clk);
    expect_item({tag, " vid sel1"}, {3'b0, v1}); observe({3'b0, vid});
    expect_item({tag, " smbOn"}, {7'b0, on});    observe({7'b0, smbOn});
    expect_item({tag, " sdaOe idle"}, 8'h00);     observe({7'b0, sdaOe});
    sel = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset values
    checkPorts(5'h1F, 5'h1F, 1'b0, "R1");

    // R8 + R12: read after reset through repeated START
    readWord(8'h20, 8'hF8, 8'hF8, "R8 R12 read reset regs");

    // R5 + R6: word write, low bits of data set
    writeWord(8'hE2, 8'h20, 8'h57, 8'hAF, "R5 write ack", 1'b0);
    checkPorts(5'h0A, 5'h15, 1'b0, "R5 R6");
    readWord(8'h21, 8'h50, 8'hA8, "R8 readback");

    // R5: command low bits are don't care
    writeWord(8'hE2, 8'h3F, 8'h08, 8'hF0, "R5 cmd 3F ack", 1'b0);
    checkPorts(5'h01, 5'h1E, 1'b0, "R5 cmd 3F");

    // R4: invalid commands
    writeWord(8'hE2, 8'hA0, 8'h00, 8'h00, "R4 write ack", 1'b0);
    checkPorts(5'h01, 5'h1E, 1'b0, "R4 write");
    readWord(8'hE0, 8'hFF, 8'hFF, "R4 read released");

    // R2: foreign address
    writeWord(8'hC4, 8'h20, 8'h00, 8'h00, "R2 no ack", 1'b1);
    checkPorts(5'h01, 5'h1E, 1'b0, "R2");

    // R5: STOP before Data High
    busStart();
    sendByte(8'hE2, "R5 partial", 1'b0);
    sendByte(8'h20, "R5 partial", 1'b0);
    sendByte(8'h00, "R5 partial", 1'b0);
    busStop();
    checkPorts(5'h01, 5'h1E, 1'b0, "R5 partial");

    // R11: valid reserved write codes
    writeWord(8'hE2, 8'h00, 8'h01, 8'h00, "R11 cmd 00 ack", 1'b0);
    writeWord(8'hE2, 8'h60, 8'h01, 8'h00, "R11 cmd 60 ack", 1'b0);
    checkPorts(5'h01, 5'h1E, 1'b0, "R11");

    // R7 + R9: enable bit
    writeWord(8'hE2, 8'h40, 8'h01, 8'h00, "R7 set ack", 1'b0);
    checkPorts(5'h01, 5'h1E, 1'b1, "R7 set");
    readWord(8'h40, 8'h01, 8'h00, "R9 read on");
    readWord(8'h7F, 8'h01, 8'h00, "R9 read on cmd 7F");
    writeWord(8'hE2, 8'h40, 8'hFE, 8'hFF, "R7 clear ack", 1'b0);
    checkPorts(5'h01, 5'h1E, 1'b0, "R7 clear");

    // R10: host NACK ends the read, R8 with command 000
    busStart();
    sendByte(8'hE2, "R10", 1'b0);
    sendByte(8'h00, "R10", 1'b0);
    busStart();
    sendByte(8'hE3, "R10", 1'b0);
    recvByte(8'h08, "R8 R10 low byte", 1'b0);
    recvByte(8'hFF, "R10 released", 1'b0);
    busStop();
    checkPorts(5'h01, 5'h1E, 1'b0, "R10 end");

    repeat (20) @(negedge clk);
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d items left expected 0", expQ.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule